// File: doc/BRIEF.md
# Asynchronous External Bus Timing Controller

This block turns single 32-bit read and write requests from inside the chip into cycles on an asynchronous external bus with four chip-select banks. Each bank has its own 32-bit configuration word. The word gives separate setup, strobe and hold lengths for reads and for writes. It also holds an option to stretch the strobe until an active-low ready input is seen, and the width of the external data bus (8, 16 or 32 bits).

A request is taken only while the controller is idle. The controller then drives the bank's active-low chip select, the address, the write data and the read or write strobe. When the bank is narrower than 32 bits, the word is split into consecutive bus cycles, lowest part first. Each of these cycles uses the full timing. When the access is complete, the controller gives a one-cycle done pulse and, for reads, the assembled word.

Top module: `async_bus_ctrl`

## Requirements
- R1: After reset every bank configuration word reads 0x3FFF_FFF2. The fields are: bit 30 wait enable, 29:26 write setup, 25:20 write strobe, 19:17 write hold, 16:13 read setup, 12:7 read strobe, 6:4 read hold, 1:0 bus size.
- R2: Bits 31, 3 and 2 of a configuration word ignore writes and read as zero. All other bits read back what was written. A write to one bank leaves the other banks unchanged.
- R3: In a write, the address, data and chip select are valid for (write setup + 1) cycles before the write strobe goes low. The strobe then stays low for (write strobe + 1) cycles. Address, data and chip select then stay valid for (write hold + 1) more cycles. Address and data do not change while the strobe is low.
- R4: A read follows the same three-phase timing on the read strobe, using the read setup, read strobe and read hold fields.
- R5: Only the chip select of the requested bank goes low, at most one chip select is low at a time, and the read and write strobes are never low together.
- R6: With the wait enable bit at 0, the ready input has no effect: the strobe length is exactly the programmed length, even with ready held inactive (high).
- R7: With the wait enable bit at 1, ready passes through a two-flop synchronizer. The strobe is stretched one cycle at a time past its programmed length until the synchronized ready is low. It rises on the second clock edge after the one that first samples ready low.
- R8: Bus size 00 gives four byte cycles at addresses base+0..3. Size 01 gives two 16-bit cycles at base+0 and base+2. Size 1x gives one 32-bit cycle. Cycles go lowest part first. Write data for each cycle sits in the low lanes of the data output, with the unused lanes at zero.
- R9: Read data is sampled in the last strobe cycle of each bus cycle and assembled in order into the returned word. Completion is a done pulse exactly one cycle long, with the read word valid from that cycle onward.
- R10: Requests are taken only while the controller is idle (ready-for-request high). A request presented during a transfer is ignored: it causes no extra bus cycle and does not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a configuration word |
| cfg_sel | input | 2 | Bank whose configuration word is written or read |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word of the selected bank |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_addr | input | 24 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Controller idle, a request is taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read word |
| ext_cs_n | output | 4 | Active-low chip selects, one per bank |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_addr | output | 24 | External byte address |
| ext_dout | output | 32 | External write data |
| ext_doe | output | 1 | Data output enable during writes |
| ext_din | input | 32 | External read data |
| ext_rdy_n | input | 1 | Active-low ready from the device |

## Verification
Random configurations with short timing fields, all three bus widths and random banks, addresses and data exercise the phase counters and the lane splitting together. A wrong count in any single phase, or a wrong lane or address order, shows up in the per-cycle record the bench rebuilds from the pins. The device model drives garbage whenever the read strobe is high, so a sample taken outside the strobe cannot go unnoticed. Directed cases cover the rest: the reset timing values, ready held inactive with waiting off versus ready dropped late with waiting on (which pins down the synchronizer latency), and a request held during a transfer (which tells real idle gating apart from a late re-trigger).

// File: rtl/abus_pkg.sv
package abus_pkg;
  localparam logic [31:0] CFG_RESET = 32'h3FFF_FFF2;
  localparam logic [31:0] CFG_MASK  = 32'h7FFF_FFF3;

  typedef struct packed {
    logic       rsv_hi;
    logic       wait_en;
    logic [3:0] wr_setup;
    logic [5:0] wr_strobe;
    logic [2:0] wr_hold;
    logic [3:0] rd_setup;
    logic [5:0] rd_strobe;
    logic [2:0] rd_hold;
    logic [1:0] rsv_lo;
    logic [1:0] bus_size;
  } bank_cfg_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // 0: byte lanes, 1: half-word lanes, 2: full word
  function automatic logic [1:0] width_code(input logic [1:0] sz);
    return sz[1] ? 2'd2 : (sz[0] ? 2'd1 : 2'd0);
  endfunction

  function automatic logic [5:0] phase_len(input bank_cfg_t c, input logic wr,
                                           input phase_e p);
    logic [5:0] v;
    case (p)
      PH_SETUP:  v = wr ? {2'b00, c.wr_setup} : {2'b00, c.rd_setup};
      PH_STROBE: v = wr ? c.wr_strobe : c.rd_strobe;
      PH_HOLD:   v = wr ? {3'b000, c.wr_hold} : {3'b000, c.rd_hold};
      default:   v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/abus_cfg_regs.sv
module abus_cfg_regs #(
  parameter int NBANK = 4,
  parameter int BW    = $clog2(NBANK)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [BW-1:0]           sel,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic [NBANK-1:0][31:0]  cfg_all
);
  import abus_pkg::*;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        cfg_all[b] <= CFG_RESET;
      else if (we && sel == BW'(b))
        cfg_all[b] <= wdata & CFG_MASK;
    end
  end

  assign rdata = cfg_all[sel];
endmodule

// File: rtl/abus_sync2.sv
module abus_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/abus_seq.sv
module abus_seq #(
  parameter int NBANK = 4,
  parameter int AW    = 24,
  parameter int BW    = $clog2(NBANK)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NBANK-1:0][31:0] cfg_all,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [BW-1:0]          req_bank,
  input  logic [AW-1:0]          req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   req_ready,
  output logic                   done,
  output logic [31:0]            rdata,
  input  logic                   rdy_sync_n,
  input  logic [31:0]            din,
  output logic [NBANK-1:0]       cs_n,
  output logic                   rd_n,
  output logic                   wr_n,
  output logic [AW-1:0]          addr,
  output logic [31:0]            dout,
  output logic                   doe
);
  import abus_pkg::*;

  phase_e        state, st_n;
  logic [5:0]    cnt, cnt_n;
  logic [1:0]    beat, beat_n;
  logic          is_wr;
  logic [BW-1:0] bank;
  logic [AW-1:0] base;
  logic [31:0]   wbuf, rbuf;
  logic          fin, cap;

  // values that the next state will present on the pins
  logic          wr_sel_n;
  logic [BW-1:0] bank_n;
  logic [AW-1:0] base_n;
  logic [31:0]   wd_n;
  bank_cfg_t     cfg_cur, cfg_nx;
  logic [1:0]    wc_cur, wc_nx, last_beat;

  assign cfg_cur   = bank_cfg_t'(cfg_all[bank]);
  assign wc_cur    = width_code(cfg_cur.bus_size);
  assign last_beat = (wc_cur == 2'd2) ? 2'd0 : ((wc_cur == 2'd1) ? 2'd1 : 2'd3);
  assign req_ready = (state == PH_IDLE);

  always_comb begin
    st_n   = state;
    cnt_n  = cnt;
    beat_n = beat;
    fin    = 1'b0;
    cap    = 1'b0;
    case (state)
      PH_IDLE: begin
        beat_n = '0;
        if (req_valid) begin
          st_n  = PH_SETUP;
          cnt_n = phase_len(bank_cfg_t'(cfg_all[req_bank]), req_write, PH_SETUP);
        end
      end
      PH_SETUP: begin
        if (cnt != '0) cnt_n = cnt - 6'd1;
        else begin
          st_n  = PH_STROBE;
          cnt_n = phase_len(cfg_cur, is_wr, PH_STROBE);
        end
      end
      PH_STROBE: begin
        if (cnt != '0) cnt_n = cnt - 6'd1;
        else if (!cfg_cur.wait_en || !rdy_sync_n) begin
          st_n  = PH_HOLD;
          cnt_n = phase_len(cfg_cur, is_wr, PH_HOLD);
          cap   = 1'b1;
        end
      end
      default: begin
        if (cnt != '0) cnt_n = cnt - 6'd1;
        else if (beat != last_beat) begin
          st_n   = PH_SETUP;
          beat_n = beat + 2'd1;
          cnt_n  = phase_len(cfg_cur, is_wr, PH_SETUP);
        end else begin
          st_n = PH_IDLE;
          fin  = 1'b1;
        end
      end
    endcase
  end

  always_comb begin
    if (state == PH_IDLE) begin
      bank_n   = req_bank;
      wr_sel_n = req_write;
      base_n   = req_addr;
      wd_n     = req_wdata;
    end else begin
      bank_n   = bank;
      wr_sel_n = is_wr;
      base_n   = base;
      wd_n     = wbuf;
    end
    cfg_nx = bank_cfg_t'(cfg_all[bank_n]);
    wc_nx  = width_code(cfg_nx.bus_size);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_IDLE;
      cnt   <= '0;
      beat  <= '0;
      is_wr <= 1'b0;
      bank  <= '0;
      base  <= '0;
      wbuf  <= '0;
      rbuf  <= '0;
      done  <= 1'b0;
      rdata <= '0;
      cs_n  <= '1;
      rd_n  <= 1'b1;
      wr_n  <= 1'b1;
      addr  <= '0;
      dout  <= '0;
      doe   <= 1'b0;
    end else begin
      state <= st_n;
      cnt   <= cnt_n;
      beat  <= beat_n;
      if (state == PH_IDLE && req_valid) begin
        is_wr <= req_write;
        bank  <= req_bank;
        base  <= req_addr;
        wbuf  <= req_wdata;
      end
      if (cap) begin
        case (wc_cur)
          2'd0:    rbuf[{beat, 3'b000} +: 8]     <= din[7:0];
          2'd1:    rbuf[{beat[0], 4'b0000} +: 16] <= din[15:0];
          default: rbuf <= din;
        endcase
      end
      done <= fin;
      if (fin && !is_wr) rdata <= rbuf;
      // pin registers follow the next state
      cs_n <= '1;
      if (st_n != PH_IDLE) cs_n[bank_n] <= 1'b0;
      rd_n <= !(st_n == PH_STROBE && !wr_sel_n);
      wr_n <= !(st_n == PH_STROBE && wr_sel_n);
      doe  <= (st_n != PH_IDLE) && wr_sel_n;
      addr <= base_n + (AW'(beat_n) << wc_nx);
      case (wc_nx)
        2'd0:    dout <= {24'h0, wd_n[{beat_n, 3'b000} +: 8]};
        2'd1:    dout <= {16'h0, wd_n[{beat_n[0], 4'b0000} +: 16]};
        default: dout <= wd_n;
      endcase
    end
  end
endmodule

// File: rtl/async_bus_ctrl.sv
module async_bus_ctrl #(
  parameter int NBANK = 4,
  parameter int AW    = 24,
  parameter int BW    = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [BW-1:0]    cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [BW-1:0]    req_bank,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  output logic             req_ready,
  output logic             done,
  output logic [31:0]      rdata,
  output logic [NBANK-1:0] ext_cs_n,
  output logic             ext_rd_n,
  output logic             ext_wr_n,
  output logic [AW-1:0]    ext_addr,
  output logic [31:0]      ext_dout,
  output logic             ext_doe,
  input  logic [31:0]      ext_din,
  input  logic             ext_rdy_n
);
  logic [NBANK-1:0][31:0] cfg_all;
  logic                   rdy_sync_n;

  abus_cfg_regs #(.NBANK(NBANK), .BW(BW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg_all(cfg_all)
  );

  abus_sync2 #(.RST_VAL(1'b1)) u_rdy (
    .clk(clk), .rst(rst), .d(ext_rdy_n), .q(rdy_sync_n)
  );

  abus_seq #(.NBANK(NBANK), .AW(AW), .BW(BW)) u_seq (
    .clk(clk), .rst(rst), .cfg_all(cfg_all),
    .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .rdy_sync_n(rdy_sync_n), .din(ext_din),
    .cs_n(ext_cs_n), .rd_n(ext_rd_n), .wr_n(ext_wr_n), .addr(ext_addr),
    .dout(ext_dout), .doe(ext_doe)
  );
endmodule

// File: rtl/abus_chk.sv
module abus_chk #(
  parameter int NBANK = 4,
  parameter int AW    = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             done,
  input logic [NBANK-1:0] ext_cs_n,
  input logic             ext_rd_n,
  input logic             ext_wr_n,
  input logic [AW-1:0]    ext_addr,
  input logic [31:0]      ext_dout,
  input logic             ext_doe
);
  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $countones(~ext_cs_n) <= 1); // R5
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n)); // R5
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n) |-> (ext_cs_n != '1)); // R3
  AST_WR_DRIVES_DATA: assert property (@(posedge clk) disable iff (rst)
    !ext_wr_n |-> ext_doe); // R3
  AST_WR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ext_wr_n && $past(!ext_wr_n)) |-> ($stable(ext_addr) && $stable(ext_dout))); // R3
  AST_RD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n && $past(!ext_rd_n)) |-> $stable(ext_addr)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (ext_cs_n != '1) |-> !req_ready); // R10
endmodule

bind async_bus_ctrl abus_chk #(.NBANK(NBANK), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .done(done),
  .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
  .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe)
);

// File: tb/async_bus_ctrl_test.sv
module async_bus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, done;
  logic [31:0] rdata;
  logic [3:0]  ext_cs_n;
  logic        ext_rd_n, ext_wr_n, ext_doe;
  logic [23:0] ext_addr;
  logic [31:0] ext_dout, ext_din;
  logic        ext_rdy_n = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  async_bus_ctrl uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_write(req_write), .req_bank(req_bank), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rdata(rdata),
    .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
    .ext_din(ext_din), .ext_rdy_n(ext_rdy_n)
  );

  // device model: byte at address x is x*29+0x3C; garbage outside the read strobe
  function automatic logic [7:0] mem_byte(input logic [23:0] x);
    return 8'(x[7:0] * 8'd29 + 8'h3C);
  endfunction
  function automatic logic [31:0] mem_word(input logic [23:0] a);
    return {mem_byte(a + 24'd3), mem_byte(a + 24'd2), mem_byte(a + 24'd1), mem_byte(a)};
  endfunction
  assign ext_din = ext_rd_n ? 32'hDEAD_BEEF : mem_word(ext_addr);

  function automatic logic [31:0] mkcfg(input bit ew, input int wsu, input int wst,
      input int whd, input int rsu, input int rst_, input int rhd, input int sz);
    return {1'b0, ew, 4'(wsu), 6'(wst), 3'(whd), 4'(rsu), 6'(rst_), 3'(rhd), 2'b00, 2'(sz)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pin monitor: rebuilds per-bus-cycle phase lengths
  int ph = 0, c_su = 0, c_st = 0, c_hd = 0, nb = 0, viol = 0;
  int b_su[8], b_st[8], b_hd[8];
  logic [23:0] b_addr[8];
  logic [31:0] b_dat[8];
  logic        b_wr[8];
  logic [3:0]  b_cs[8];
  logic [23:0] cur_a;
  logic [31:0] t_dat;
  logic        t_wr;
  logic [3:0]  t_cs;
  logic        cs_any, strb;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      cs_any = (ext_cs_n != 4'hF);
      strb   = !ext_rd_n || !ext_wr_n;
      if ($countones(~ext_cs_n) > 1 || (!ext_rd_n && !ext_wr_n)) viol++;
      case (ph)
        0: if (cs_any) begin ph = 1; c_su = 1; cur_a = ext_addr; end
        1: if (strb) begin
             ph = 2; c_st = 1; t_wr = !ext_wr_n; t_dat = ext_dout; t_cs = ext_cs_n;
           end else c_su++;
        2: if (strb) c_st++; else begin ph = 3; c_hd = 1; end
        default: if (cs_any && ext_addr == cur_a && !strb) c_hd++;
          else begin
            if (nb < 8) begin
              b_su[nb] = c_su; b_st[nb] = c_st; b_hd[nb] = c_hd; b_addr[nb] = cur_a;
              b_dat[nb] = t_dat; b_wr[nb] = t_wr; b_cs[nb] = t_cs;
            end
            nb++;
            if (cs_any) begin ph = 1; c_su = 1; cur_a = ext_addr; end else ph = 0;
          end
      endcase
    end
  end

  task automatic cfg_write(input logic [1:0] b, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = b; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input logic [1:0] b, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_sel = b;
    #1;
    check(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  // one access; st_exp >= 0 overrides the expected strobe length of every bus cycle
  task automatic xfer(input logic [1:0] bk, input bit wr, input logic [23:0] a,
                      input logic [31:0] wd, input logic [31:0] cv, input int st_exp);
    int t, nx, esu, est, ehd, sh;
    bit ok_t, ok_b, ok_d;
    logic [31:0] lane;
    @(negedge clk);
    nb = 0;
    check(req_ready == 1'b1, "R10 idle before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_bank = bk; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
    #1;
    check(done == 1'b0 && req_ready == 1'b1, "R9 done one cycle", 32'(done), 32'd0);
    nx  = cv[1] ? 1 : (cv[0] ? 2 : 4);
    sh  = cv[1] ? 0 : (cv[0] ? 1 : 0);
    esu = wr ? int'(cv[29:26]) + 1 : int'(cv[16:13]) + 1;
    est = (st_exp >= 0) ? st_exp : (wr ? int'(cv[25:20]) + 1 : int'(cv[12:7]) + 1);
    ehd = wr ? int'(cv[19:17]) + 1 : int'(cv[6:4]) + 1;
    ok_t = 1'b1; ok_b = (nb == nx); ok_d = 1'b1;
    for (int k = 0; k < nx && k < nb && k < 8; k++) begin
      if (b_su[k] != esu || b_st[k] != est || b_hd[k] != ehd) ok_t = 1'b0;
      if (b_addr[k] != a + 24'(k << sh) || b_wr[k] != wr) ok_b = 1'b0;
      if (b_cs[k] != ~(4'b0001 << bk)) ok_b = 1'b0;
      if (wr) begin
        lane = cv[1] ? wd : (cv[0] ? {16'h0, wd[k*16 +: 16]} : {24'h0, wd[k*8 +: 8]});
        if (b_dat[k] != lane) ok_d = 1'b0;
      end
    end
    if (wr) begin
      check(ok_t, "R3 write phase lengths", 32'(b_st[0]), 32'(est));
      check(ok_d, "R8 write lanes", b_dat[0], wd);
    end else begin
      check(ok_t, "R4 read phase lengths", 32'(b_st[0]), 32'(est));
      check(rdata == mem_word(a), "R9 read assembly", rdata, mem_word(a));
    end
    check(ok_b, "R8 bus cycle count/address", 32'(nb), 32'(nx));
  endtask

  initial begin
    logic [31:0] cv;
    logic [1:0]  bk;
    int          n_hold;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(ext_cs_n == 4'hF && ext_rd_n && ext_wr_n && !done && req_ready,
          "R5 idle pins after reset", {28'h0, ext_cs_n}, 32'hF);

    // R1: reset values
    for (int b = 0; b < 4; b++) cfg_check(2'(b), 32'h3FFF_FFF2, "R1 reset value");

    // R2: reserved bits, bank isolation
    cfg_write(2'd2, 32'hFFFF_FFFF);
    cfg_check(2'd2, 32'h7FFF_FFF3, "R2 reserved bits read zero");
    cfg_check(2'd1, 32'h3FFF_FFF2, "R2 other bank unchanged");
    cfg_write(2'd2, 32'h0000_0000);
    cfg_check(2'd2, 32'h0000_0000, "R2 all-zero write");
    cfg_write(2'd2, 32'h3FFF_FFF2);

    // R3 with reset timing, plus R10: request held during the transfer is ignored
    fork
      xfer(2'd0, 1'b1, 24'h00_1200, 32'hA5C3_1F07, 32'h3FFF_FFF2, -1);
      begin
        repeat (6) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_bank = 2'd3;
        req_addr = 24'h00_7770; req_wdata = 32'h1111_2222;
        for (int i = 0; i < 10; i++) begin
          @(negedge clk);
          #1;
          check(req_ready == 1'b0, "R10 busy refuses request", 32'(req_ready), 32'd0);
        end
        req_valid = 1'b0;
      end
    join
    repeat (20) @(negedge clk);
    #1;
    check(nb == 1 && ext_cs_n == 4'hF, "R10 no extra bus cycle", 32'(nb), 32'd1);

    // R6: waiting off, ready held inactive has no effect
    ext_rdy_n = 1'b1;
    cv = mkcfg(1'b0, 1, 3, 2, 2, 4, 1, 2);
    cfg_write(2'd1, cv);
    xfer(2'd1, 1'b0, 24'h00_0040, 32'h0, cv, 5);   // R6 read strobe 4+1
    xfer(2'd1, 1'b1, 24'h00_0044, 32'hCAFE_F00D, cv, 4); // R6 write strobe 3+1

    // R7: waiting on, ready dropped late; strobe ends two samples later
    cv = mkcfg(1'b1, 1, 2, 1, 1, 3, 1, 2);
    cfg_write(2'd3, cv);
    n_hold = 4 + 6;
    repeat (4) @(negedge clk);
    fork
      xfer(2'd3, 1'b0, 24'h00_0100, 32'h0, cv, n_hold + 2);
      begin
        int seen = 0;
        while (seen < n_hold) begin
          @(negedge clk);
          if (!ext_rd_n) seen++;
        end
        ext_rdy_n = 1'b0; // R7 ready asserted after strobe count has expired
      end
    join

    // R8 directed: 8-bit and 16-bit splits
    cv = mkcfg(1'b0, 0, 0, 0, 0, 0, 0, 0);
    cfg_write(2'd2, cv);
    xfer(2'd2, 1'b1, 24'h00_0200, 32'h8877_6655, cv, -1);
    xfer(2'd2, 1'b0, 24'h00_0204, 32'h0, cv, -1);
    cv = mkcfg(1'b0, 2, 1, 0, 1, 2, 3, 1);
    cfg_write(2'd2, cv);
    xfer(2'd2, 1'b1, 24'h00_0300, 32'h1357_9BDF, cv, -1);
    xfer(2'd2, 1'b0, 24'h00_0302, 32'h0, cv, -1);

    // random mix
    for (int i = 0; i < 40; i++) begin
      bk = 2'($urandom_range(0, 3));
      cv = mkcfg(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 5),
                 $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 5),
                 $urandom_range(0, 3), $urandom_range(0, 3));
      cfg_write(bk, cv);
      xfer(bk, 1'($urandom_range(0, 1)), {$urandom_range(0, 24'h3F_FFFF), 2'b00}[23:0],
           $urandom, cv, -1);
    end

    check(viol == 0, "R5 chip select exclusivity", 32'(viol), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule